// File: doc/BRIEF.md
# Polled HDLC Response Frame Transmitter

This block is the transmit side of a secondary station on a polled HDLC link. A receive path outside the block hands it the control byte of each frame the primary station sends. The block keeps only Receive Ready (RR) supervisory frames and splits them into polls and acknowledges. A poll is answered with one frame. If the CPU has loaded data and issued the send command, that frame is an I-frame carrying the buffered bytes. Otherwise it is an automatic RR reply. An acknowledge releases the buffer so the CPU can load the next message.

The CPU loads a 64-byte transmit buffer through a valid/ready byte port. A status bit tells it when a block of up to 32 bytes may be written, and an interrupt pulse tells it when the buffer has been freed. Frames leave as a valid/ready byte stream. Each frame holds the address bytes, the control byte, an optional payload and a 16-bit CRC. Start-of-frame and end-of-frame markers let an external framer add flags and bit stuffing.

The back-pressure rules are the same on both streams. A byte moves on a rising clock edge only when valid and ready are both high. On the output, once `tx_valid` is high, `tx_data`, `tx_sof` and `tx_eof` hold steady until the byte is taken. On the load port, `load_ready` may drop at any time, and a byte offered while it is low is discarded.

Top module: `rr_poll_tx`

## Requirements
- R1: After reset, `tx_valid` and `pool_irq` are 0, and `fifo_writable` and `load_ready` are 1.
- R2: `load_ready` is 1 only when no send command is pending and fewer than 64 bytes are stored. `fifo_writable` is 1 only when no send command is pending and at least 32 bytes are free. A byte offered while `load_ready` is 0 is not stored.
- R3: A received control byte is an RR frame only when bits 3..0 equal 0001. Bit 4 is the poll bit. Any other control byte has no effect, and no frame starts without an RR poll.
- R4: An RR poll that arrives with no send command pending produces an automatic reply frame: the address bytes, the control byte 0x11 (RR with the final bit at bit 4), then the CRC.
- R5: An RR poll that arrives with a send command pending produces an I-frame: the address bytes, the control byte 0x10, every stored byte in load order, then the CRC. The first byte is offered in the cycle after the poll.
- R6: With `addr_two_byte` = 0 the address field is the single byte `addr_first`. With `addr_two_byte` = 1 it is `addr_first` followed by `addr_second`.
- R7: The CRC is CRC-16/CCITT (polynomial 0x1021, bit-reflected, preset 0xFFFF) over the address, control and payload bytes. Its ones' complement is sent low byte first. A CRC run over the whole frame, including these two bytes, leaves the residue 0xF0B8.
- R8: `tx_sof` marks the first byte of a frame and `tx_eof` marks the last. While `tx_valid` is high and `tx_ready` is low, the byte and its markers hold. `tx_valid` is low in the cycle after the last byte is taken.
- R9: An RR acknowledge (poll bit 0) received while no frame is being sent empties the buffer and cancels the send command. In the next cycle `pool_irq` is high for one cycle and `fifo_writable` is 1.
- R10: Sending an I-frame does not release the buffer. A later poll that comes before an acknowledge gets the same I-frame again.
- R11: RR polls and acknowledges that arrive while a frame is being sent are ignored. They change neither that frame nor the buffer, and they raise no interrupt.
- R12: A send command issued while the buffer is empty is ignored, so the next poll still gets the automatic RR reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_two_byte | input | 1 | Address length select: 0 sends one address byte, 1 sends two |
| addr_first | input | 8 | First address byte |
| addr_second | input | 8 | Second address byte |
| rx_ctrl_valid | input | 1 | One-cycle strobe: a received control byte is present |
| rx_ctrl | input | 8 | Received control byte |
| load_valid | input | 1 | CPU load byte valid |
| load_ready | output | 1 | Buffer accepts a load byte |
| load_data | input | 8 | CPU load byte |
| send_cmd | input | 1 | One-cycle pulse: commit the buffer contents as the next I-frame |
| fifo_writable | output | 1 | Status bit: a block of up to 32 bytes may be written |
| pool_irq | output | 1 | One-cycle interrupt pulse: the buffer was freed by an acknowledge |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream framer takes the byte |
| tx_data | output | 8 | Output frame byte |
| tx_sof | output | 1 | Output byte is the first of its frame |
| tx_eof | output | 1 | Output byte is the last of its frame |

## Verification
The assertions assume that the control strobe and the send command are single-cycle pulses. They also assume that `addr_two_byte` and the address bytes do not change while a frame is being sent, and that the downstream framer may hold `tx_ready` low for any number of cycles. The stimulus sets up the address inputs before each poll. It drives every pulse for exactly one cycle on the falling clock edge. It toggles `tx_ready` in regular stall patterns, so the hold rule is exercised without changing the frames that are expected. Mid-frame polls and acknowledges are injected on purpose to check that they have no effect.

// File: rtl/rr_poll_tx_pkg.sv
package rr_poll_tx_pkg;

  localparam logic [7:0] CTRL_IFRAME = 8'h10;
  localparam logic [7:0] CTRL_RR_FIN = 8'h11;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ADR1,
    SEQ_ADR2,
    SEQ_CTRL,
    SEQ_DATA,
    SEQ_CRCL,
    SEQ_CRCH
  } seq_state_t;

  // One byte through the reflected CCITT CRC, LSB first.
  function automatic logic [15:0] crc_step(input logic [15:0] crc_in,
                                           input logic [7:0] b);
    logic [15:0] c;
    c = crc_in ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rr_poll_tx_fifo.sv
module rr_poll_tx_fifo #(
  parameter int DEPTH = 64,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          clear,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (wr_en) begin
      count <= count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clear) begin
      mem[count[AW-1:0]] <= wr_data;
    end
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/rr_poll_tx_crc.sv
module rr_poll_tx_crc
  import rr_poll_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc <= CRC_PRESET;
    end else if (init) begin
      crc <= CRC_PRESET;
    end else if (upd) begin
      crc <= crc_step(crc, din);
    end
  end

endmodule

// File: rtl/rr_poll_tx_seq.sv
module rr_poll_tx_seq
  import rr_poll_tx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_iframe,
  input  logic          addr_two_byte,
  input  logic [7:0]    addr_first,
  input  logic [7:0]    addr_second,
  input  logic [CW-1:0] count,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] rd_idx,
  output logic          busy,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  output logic          tx_sof,
  output logic          tx_eof
);

  seq_state_t state;
  logic       iframe_q;
  logic       take;
  logic       last_data;
  logic       crc_upd;
  logic [15:0] crc;

  assign busy      = (state != SEQ_IDLE);
  assign tx_valid  = busy;
  assign take      = tx_valid && tx_ready;
  assign tx_sof    = (state == SEQ_ADR1);
  assign tx_eof    = (state == SEQ_CRCH);
  assign last_data = (CW'(rd_idx) == count - CW'(1));
  assign crc_upd   = take && (state inside {SEQ_ADR1, SEQ_ADR2, SEQ_CTRL, SEQ_DATA});

  always_comb begin
    unique case (state)
      SEQ_ADR1: tx_data = addr_first;
      SEQ_ADR2: tx_data = addr_second;
      SEQ_CTRL: tx_data = iframe_q ? CTRL_IFRAME : CTRL_RR_FIN;
      SEQ_DATA: tx_data = rd_data;
      SEQ_CRCL: tx_data = ~crc[7:0];
      SEQ_CRCH: tx_data = ~crc[15:8];
      default:  tx_data = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      iframe_q <= 1'b0;
      rd_idx   <= '0;
    end else if (state == SEQ_IDLE) begin
      if (start) begin
        state    <= SEQ_ADR1;
        iframe_q <= start_iframe;
        rd_idx   <= '0;
      end
    end else if (take) begin
      unique case (state)
        SEQ_ADR1: state <= addr_two_byte ? SEQ_ADR2 : SEQ_CTRL;
        SEQ_ADR2: state <= SEQ_CTRL;
        SEQ_CTRL: state <= iframe_q ? SEQ_DATA : SEQ_CRCL;
        SEQ_DATA: begin
          rd_idx <= rd_idx + AW'(1);
          if (last_data) state <= SEQ_CRCL;
        end
        SEQ_CRCL: state <= SEQ_CRCH;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  rr_poll_tx_crc crc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .init  (start && !busy),
    .upd   (crc_upd),
    .din   (tx_data),
    .crc   (crc)
  );

endmodule

// File: rtl/rr_poll_tx.sv
module rr_poll_tx
  import rr_poll_tx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int BLOCK = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_two_byte,
  input  logic [7:0] addr_first,
  input  logic [7:0] addr_second,
  input  logic       rx_ctrl_valid,
  input  logic [7:0] rx_ctrl,
  input  logic       load_valid,
  output logic       load_ready,
  input  logic [7:0] load_data,
  input  logic       send_cmd,
  output logic       fifo_writable,
  output logic       pool_irq,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  output logic       tx_sof,
  output logic       tx_eof
);

  logic          rr_hit;
  logic          poll_ev;
  logic          ack_ev;
  logic          busy;
  logic          committed;
  logic [CW-1:0] count;
  logic [AW-1:0] rd_idx;
  logic [7:0]    rd_data;

  // Receive Ready supervisory: low nibble 0001, poll/final at bit 4.
  assign rr_hit  = rx_ctrl_valid && (rx_ctrl[3:0] == 4'b0001);
  assign poll_ev = rr_hit && rx_ctrl[4] && !busy;
  assign ack_ev  = rr_hit && !rx_ctrl[4] && !busy;

  assign load_ready    = !committed && (count < CW'(DEPTH));
  assign fifo_writable = !committed && (count <= CW'(DEPTH - BLOCK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      committed <= 1'b0;
      pool_irq  <= 1'b0;
    end else begin
      pool_irq <= ack_ev;
      if (ack_ev) begin
        committed <= 1'b0;
      end else if (send_cmd && (count != '0)) begin
        committed <= 1'b1;
      end
    end
  end

  rr_poll_tx_fifo #(.DEPTH(DEPTH), .DW(8)) fifo_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (load_valid && load_ready),
    .wr_data (load_data),
    .clear   (ack_ev),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .count   (count)
  );

  rr_poll_tx_seq #(.DEPTH(DEPTH)) seq_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (poll_ev),
    .start_iframe  (committed),
    .addr_two_byte (addr_two_byte),
    .addr_first    (addr_first),
    .addr_second   (addr_second),
    .count         (count),
    .rd_data       (rd_data),
    .rd_idx        (rd_idx),
    .busy          (busy),
    .tx_valid      (tx_valid),
    .tx_ready      (tx_ready),
    .tx_data       (tx_data),
    .tx_sof        (tx_sof),
    .tx_eof        (tx_eof)
  );

endmodule

// File: rtl/rr_poll_tx_chk.sv
module rr_poll_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_ctrl_valid,
  input logic [7:0] rx_ctrl,
  input logic       load_ready,
  input logic       fifo_writable,
  input logic       pool_irq,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_sof,
  input logic       tx_eof
);

  logic rx_poll, rx_ack;
  assign rx_poll = rx_ctrl_valid && (rx_ctrl[3:0] == 4'b0001) && rx_ctrl[4];
  assign rx_ack  = rx_ctrl_valid && (rx_ctrl[3:0] == 4'b0001) && !rx_ctrl[4];

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

  assert_end_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_eof |=> !tx_valid);

  assert_sof_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_sof);

  assert_poll_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid && !rx_poll |=> !tx_valid);

  assert_ack_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack && !tx_valid |=> pool_irq && fifo_writable);

  assert_busy_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ack && tx_valid |=> !pool_irq);

  assert_writable_room_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_writable |-> load_ready);

endmodule

bind rr_poll_tx rr_poll_tx_chk chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_ctrl_valid (rx_ctrl_valid),
  .rx_ctrl       (rx_ctrl),
  .load_ready    (load_ready),
  .fifo_writable (fifo_writable),
  .pool_irq      (pool_irq),
  .tx_valid      (tx_valid),
  .tx_ready      (tx_ready),
  .tx_data       (tx_data),
  .tx_sof        (tx_sof),
  .tx_eof        (tx_eof)
);

// File: tb/rr_poll_tx_tb_top.sv
module rr_poll_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_two_byte = 1'b0;
  logic [7:0] addr_first = 8'hA5;
  logic [7:0] addr_second = 8'h3C;
  logic       rx_ctrl_valid = 1'b0;
  logic [7:0] rx_ctrl = 8'h00;
  logic       load_valid = 1'b0;
  logic       load_ready;
  logic [7:0] load_data = 8'h00;
  logic       send_cmd = 1'b0;
  logic       fifo_writable;
  logic       pool_irq;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       tx_sof;
  logic       tx_eof;

  int checks = 0;
  int failures = 0;
  logic [7:0] sent [64];
  int nsent = 0;
  logic [7:0] got [80];
  int glen = 0;
  logic [7:0] exp_b [80];
  int elen = 0;

  always #4 clk = ~clk;

  rr_poll_tx dut_i (
    .clk(clk), .rst_n(rst_n), .addr_two_byte(addr_two_byte),
    .addr_first(addr_first), .addr_second(addr_second),
    .rx_ctrl_valid(rx_ctrl_valid), .rx_ctrl(rx_ctrl),
    .load_valid(load_valid), .load_ready(load_ready), .load_data(load_data),
    .send_cmd(send_cmd), .fifo_writable(fifo_writable), .pool_irq(pool_irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] fcs(input logic [15:0] c0, input logic [7:0] b);
    logic [15:0] c;
    c = c0 ^ {8'h00, b};
    for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  task automatic rx_send(input logic [7:0] c);
    @(negedge clk);
    rx_ctrl_valid = 1'b1;
    rx_ctrl = c;
    @(negedge clk);
    rx_ctrl_valid = 1'b0;
  endtask

  task automatic load_byte(input logic [7:0] b);
    @(negedge clk);
    if (load_ready) begin
      sent[nsent] = b;
      nsent++;
    end
    load_valid = 1'b1;
    load_data = b;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic pulse_cmd();
    @(negedge clk);
    send_cmd = 1'b1;
    @(negedge clk);
    send_cmd = 1'b0;
  endtask

  // Called at a negedge; takes one frame. stall>0 holds ready low every stall-th cycle.
  // inject=1 drives a poll then an acknowledge in the middle of the frame.
  task automatic collect(input int stall, input bit inject);
    logic       pv = 1'b0;
    logic [7:0] pd = 8'h00;
    bit         done = 1'b0;
    glen = 0;
    for (int cyc = 0; cyc < 300 && !done; cyc++) begin
      tx_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
      if (inject && cyc == 2) begin rx_ctrl_valid = 1'b1; rx_ctrl = 8'h11; end
      else if (inject && cyc == 3) begin rx_ctrl_valid = 1'b1; rx_ctrl = 8'h01; end
      else rx_ctrl_valid = 1'b0;
      #1;
      if (pv) chk(tx_valid && tx_data == pd, "R8 hold under stall", int'(tx_data), int'(pd));
      if (cyc == 0) chk(tx_valid == 1'b1, "R5 first byte next cycle", int'(tx_valid), 1);
      pv = tx_valid && !tx_ready;
      pd = tx_data;
      if (tx_valid && tx_ready) begin
        if (tx_sof != (glen == 0)) chk(1'b0, "R8 sof marker", int'(tx_sof), int'(glen == 0));
        got[glen] = tx_data;
        glen++;
        if (tx_eof) done = 1'b1;
      end
      @(negedge clk);
    end
    rx_ctrl_valid = 1'b0;
    tx_ready = 1'b0;
    chk(done, "R8 eof reached", int'(done), 1);
    chk(!tx_valid, "R8 idle after eof", int'(tx_valid), 0);
  endtask

  task automatic build_exp(input bit iframe);
    logic [15:0] c = 16'hFFFF;
    elen = 0;
    exp_b[elen++] = addr_first;
    if (addr_two_byte) exp_b[elen++] = addr_second;
    exp_b[elen++] = iframe ? 8'h10 : 8'h11;
    if (iframe) for (int i = 0; i < nsent; i++) exp_b[elen++] = sent[i];
    for (int i = 0; i < elen; i++) c = fcs(c, exp_b[i]);
    c = ~c;
    exp_b[elen++] = c[7:0];
    exp_b[elen++] = c[15:8];
  endtask

  task automatic compare(input bit iframe, input string req);
    int bad = 0;
    logic [15:0] r = 16'hFFFF;
    build_exp(iframe);
    chk(glen == elen, {req, " frame length"}, glen, elen);
    for (int i = 0; i < elen && i < glen; i++) begin
      if (got[i] != exp_b[i]) begin
        if (bad == 0) chk(1'b0, {req, " frame byte"}, int'(got[i]), int'(exp_b[i]));
        bad++;
      end
    end
    if (bad == 0) chk(1'b1, req, 0, 0);
    for (int i = 0; i < glen; i++) r = fcs(r, got[i]);
    chk(r == 16'hF0B8, "R7 crc residue", int'(r), 16'hF0B8);
  endtask

  task automatic t_reset();
    #1;
    chk(!tx_valid, "R1 tx_valid", int'(tx_valid), 0);
    chk(!pool_irq, "R1 pool_irq", int'(pool_irq), 0);
    chk(fifo_writable, "R1 fifo_writable", int'(fifo_writable), 1);
    chk(load_ready, "R1 load_ready", int'(load_ready), 1);
  endtask

  task automatic t_auto_rr();
    addr_two_byte = 1'b0;
    rx_send(8'h11);
    collect(0, 1'b0);
    compare(1'b0, "R4 auto RR one-byte address R6");
    addr_two_byte = 1'b1;
    rx_send(8'h11);
    collect(3, 1'b0);
    compare(1'b0, "R6 auto RR two-byte address");
  endtask

  task automatic t_non_rr();
    int seen = 0;
    rx_send(8'h15);
    rx_send(8'h13);
    rx_send(8'h19);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (tx_valid) seen++;
    end
    chk(seen == 0, "R3 non-RR control ignored", seen, 0);
    chk(!pool_irq, "R3 no irq from non-RR", int'(pool_irq), 0);
  endtask

  task automatic t_iframe();
    addr_two_byte = 1'b0;
    nsent = 0;
    for (int i = 0; i < 5; i++) load_byte(8'h40 + 8'(i * 7));
    chk(fifo_writable, "R2 writable after 5 bytes", int'(fifo_writable), 1);
    pulse_cmd();
    #1;
    chk(!fifo_writable, "R2 not writable after command", int'(fifo_writable), 0);
    chk(!load_ready, "R2 load_ready low after command", int'(load_ready), 0);
    load_byte(8'hEE);
    rx_send(8'h11);
    collect(2, 1'b0);
    compare(1'b1, "R5 I-frame content R2");
  endtask

  task automatic t_repeat_and_busy();
    rx_send(8'h11);
    collect(0, 1'b1);
    compare(1'b1, "R11 frame unchanged by mid-frame poll/ack");
    #1;
    chk(!pool_irq, "R11 no irq from busy ack", int'(pool_irq), 0);
    rx_send(8'h11);
    collect(0, 1'b0);
    compare(1'b1, "R10 repeat poll resends I-frame");
  endtask

  task automatic t_ack();
    rx_send(8'h01);
    #1;
    chk(pool_irq, "R9 irq pulse", int'(pool_irq), 1);
    chk(fifo_writable, "R9 writable after ack", int'(fifo_writable), 1);
    @(negedge clk);
    #1;
    chk(!pool_irq, "R9 irq one cycle", int'(pool_irq), 0);
    rx_send(8'h11);
    collect(0, 1'b0);
    compare(1'b0, "R9 buffer cleared, auto RR");
  endtask

  task automatic t_full();
    nsent = 0;
    addr_two_byte = 1'b1;
    for (int i = 0; i < 32; i++) load_byte(8'(i * 13 + 1));
    #1;
    chk(fifo_writable, "R2 writable at 32 stored", int'(fifo_writable), 1);
    for (int i = 0; i < 32; i++) load_byte(8'(i * 5 + 200));
    #1;
    chk(!fifo_writable, "R2 not writable at 64", int'(fifo_writable), 0);
    chk(!load_ready, "R2 load_ready low when full", int'(load_ready), 0);
    load_byte(8'h77);
    pulse_cmd();
    rx_send(8'h11);
    collect(4, 1'b0);
    compare(1'b1, "R5 64-byte I-frame R7");
    rx_send(8'h01);
  endtask

  task automatic t_empty_cmd();
    nsent = 0;
    addr_two_byte = 1'b0;
    pulse_cmd();
    #1;
    chk(fifo_writable, "R12 writable after empty command", int'(fifo_writable), 1);
    rx_send(8'h11);
    collect(0, 1'b0);
    compare(1'b0, "R12 empty command ignored");
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_auto_rr();
    t_non_rr();
    t_iframe();
    t_repeat_and_busy();
    t_ack();
    t_full();
    t_empty_cmd();
    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule